// File: doc/BRIEF.md
# Block-Transfer Host Register Window

This block is the host side of a message-passing management channel. A host sees three byte-wide registers behind a two-bit address: a control register, a buffer port and an interrupt mask byte. Bytes that the host writes to the buffer port collect in an inbound message memory. Bytes that the host reads from the buffer port drain an outbound message memory, which a message engine fills and then commits.

The control register works on write-one-to-act bits. Depending on the bit, a 1 clears a pointer, clears an attention flag, toggles the host-busy flag, or rings a doorbell to the message engine. A doorbell also marks the controller as busy.

The message engine reads the inbound memory through its own read port and sees the inbound length counter. It loads the outbound memory through a write port and publishes a response with a commit strobe. The mask byte only stores a value. It is driven out to a separate interrupt block.

Top module: `bt_host_window`

## Requirements
- R1: After reset the control register reads 0x00, the mask reads 0x00, the buffer port reads 0xFF, the inbound length is 0 and the doorbell is low.
- R2: Only the two low address bits are decoded: 0 is control, 1 is the buffer and 2 is the mask. Address 3 always reads 0xFF, and a write to it changes no register.
- R3: Writing control with bit 2 set raises doorbell for exactly one cycle, in the cycle after the write, and sets controller-busy (control bit 7). Bit 2 itself always reads 0.
- R4: Writing control with bit 6 set inverts host-busy (control bit 6). Writing 0 there leaves host-busy unchanged.
- R5: Writing control with bit 3 set clears controller-to-host attention (bit 3). Writing control with bit 4 set clears system-management attention (bit 4). A 0 in either position leaves that flag as it is.
- R6: Each write to the buffer port stores the byte at the position given by the inbound length, then adds one to the inbound length. The engine read port returns the stored bytes.
- R7: When the inbound length is at or beyond DEPTH, a buffer write drops its byte but still adds one to the length, which saturates at its all-ones value. Bytes already stored are not disturbed.
- R8: Reading the buffer port returns outbound bytes in order while the read position is below the outbound length, and returns 0xFF otherwise. Reading the last byte returns both the position and the length to zero.
- R9: Control bit 0 clears the inbound length. Control bit 1 returns the read position to zero while keeping the outbound length, so the message can be read again from its start.
- R10: An engine commit sets the outbound length to the committed length, limited to DEPTH, and zeroes the read position. It also sets control bit 3 and clears control bit 7.
- R11: An engine system-management strobe sets control bit 4.
- R12: A write to the mask address stores the whole byte. It reads back at address 2 and is driven on the mask output.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe, one byte per cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 2 | Register offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read byte for hostAddr, valid in the access cycle |
| doorbell | output | 1 | One-cycle pulse to the message engine |
| inLen | output | $clog2(DEPTH)+2 | Inbound byte count, including overrun |
| engRdAddr | input | $clog2(DEPTH) | Engine read address into the inbound memory |
| engRdData | output | 8 | Inbound byte at engRdAddr |
| engWrEn | input | 1 | Engine write strobe for the outbound memory |
| engWrAddr | input | $clog2(DEPTH) | Outbound write address |
| engWrData | input | 8 | Outbound write byte |
| engCommit | input | 1 | Publish an outbound message |
| engCommitLen | input | $clog2(DEPTH)+2 | Length of the committed message |
| engSmsSet | input | 1 | Set system-management attention |
| maskByte | output | 8 | Stored mask byte for the interrupt block |

## Verification
The register decode is exercised with a walk of accesses over all four offsets. This walk separates correct decoding from aliasing of offset 3 onto a real register, and an inverting toggle from a plain set. Inbound traffic is tried with a short message and with an overrun past DEPTH. The overrun shows whether a dropped byte still counts and whether it leaves earlier data alone. Outbound traffic is tried with a full drain, a drain past the end and a re-read after a read-pointer clear. Together these separate the automatic zeroing at the last byte from zeroing by the pointer-clear bit. The doorbell is sampled in the cycle after the write and in the cycle after that, to confirm it is a single pulse.

// File: rtl/bt_win_pkg.sv
package bt_win_pkg;

  // Register offsets. Offset 3 is unmapped.
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_BUF  = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  // Control register bit positions. Host software decodes these positions.
  localparam int B_CLR_IN   = 0;
  localparam int B_CLR_OUT  = 1;
  localparam int B_BELL     = 2;
  localparam int B_RSP_ATN  = 3;
  localparam int B_SMS_ATN  = 4;
  localparam int B_HOST_BSY = 6;
  localparam int B_CTL_BSY  = 7;

  // Value returned for reads with nothing to return.
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // Strobes from the control side to the buffer datapath.
  typedef struct packed {
    logic clrIn;
    logic clrOutPos;
    logic pushIn;
    logic popOut;
  } bufStrobe_t;

endpackage

// File: rtl/bt_win_ram.sv
module bt_win_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     wrEn,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [WIDTH-1:0]         wrData,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [WIDTH-1:0]         rdData
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      store[wrAddr] <= wrData;
    end
  end

  assign rdData = store[rdAddr];

endmodule

// File: rtl/bt_win_ctrl.sv
module bt_win_ctrl
  import bt_win_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic [7:0] bufRdByte,
  input  logic       engCommit,
  input  logic       engSmsSet,
  output bufStrobe_t strobe,
  output logic [7:0] hostRdata,
  output logic [7:0] ctrlByte,
  output logic [7:0] maskByte,
  output logic       doorbell
);

  logic ctrlWr;
  logic maskWr;
  logic bufWr;
  logic bufRd;

  logic ctlBusy;
  logic hostBusy;
  logic rspAtn;
  logic smsAtn;
  logic bellQ;
  logic [7:0] maskQ;

  // Decode the access. Only the two low address bits exist.
  always_comb begin
    ctrlWr = hostSel && hostWr  && (hostAddr == OFS_CTRL);
    maskWr = hostSel && hostWr  && (hostAddr == OFS_MASK);
    bufWr  = hostSel && hostWr  && (hostAddr == OFS_BUF);
    bufRd  = hostSel && !hostWr && (hostAddr == OFS_BUF);
  end

  // Strobes handed to the buffer datapath.
  always_comb begin
    strobe           = '0;
    strobe.clrIn     = ctrlWr && hostWdata[B_CLR_IN];
    strobe.clrOutPos = ctrlWr && hostWdata[B_CLR_OUT];
    strobe.pushIn    = bufWr;
    strobe.popOut    = bufRd;
  end

  // Control flags. Engine events take priority over host clears.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlBusy  <= 1'b0;
      hostBusy <= 1'b0;
      rspAtn   <= 1'b0;
      smsAtn   <= 1'b0;
      bellQ    <= 1'b0;
      maskQ    <= '0;
    end else begin
      bellQ <= ctrlWr && hostWdata[B_BELL];

      if (ctrlWr && hostWdata[B_HOST_BSY]) begin
        hostBusy <= ~hostBusy;
      end

      if (engCommit) begin
        ctlBusy <= 1'b0;
      end else if (ctrlWr && hostWdata[B_BELL]) begin
        ctlBusy <= 1'b1;
      end

      if (engCommit) begin
        rspAtn <= 1'b1;
      end else if (ctrlWr && hostWdata[B_RSP_ATN]) begin
        rspAtn <= 1'b0;
      end

      if (engSmsSet) begin
        smsAtn <= 1'b1;
      end else if (ctrlWr && hostWdata[B_SMS_ATN]) begin
        smsAtn <= 1'b0;
      end

      if (maskWr) begin
        maskQ <= hostWdata;
      end
    end
  end

  // Assemble the control byte. Bits 0, 1, 2 and 5 read as 0.
  always_comb begin
    ctrlByte             = '0;
    ctrlByte[B_CTL_BSY]  = ctlBusy;
    ctrlByte[B_HOST_BSY] = hostBusy;
    ctrlByte[B_SMS_ATN]  = smsAtn;
    ctrlByte[B_RSP_ATN]  = rspAtn;
  end

  // Read mux.
  always_comb begin
    unique case (hostAddr)
      OFS_CTRL: hostRdata = ctrlByte;
      OFS_BUF:  hostRdata = bufRdByte;
      OFS_MASK: hostRdata = maskQ;
      default:  hostRdata = IDLE_BYTE;
    endcase
  end

  assign maskByte = maskQ;
  assign doorbell = bellQ;

endmodule

// File: rtl/bt_win_data.sv
module bt_win_data
  import bt_win_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bufStrobe_t                 strobe,
  input  logic [7:0]                 hostWdata,
  input  logic [$clog2(DEPTH)-1:0]   engRdAddr,
  output logic [7:0]                 engRdData,
  input  logic                       engWrEn,
  input  logic [$clog2(DEPTH)-1:0]   engWrAddr,
  input  logic [7:0]                 engWrData,
  input  logic                       engCommit,
  input  logic [$clog2(DEPTH)+1:0]   engCommitLen,
  output logic [7:0]                 bufRdByte,
  output logic [$clog2(DEPTH)+1:0]   inLen,
  output logic [$clog2(DEPTH)+1:0]   outLen
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = IDX_W + 2;
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] inCnt;
  logic [LEN_W-1:0] rdPos;
  logic [LEN_W-1:0] outCnt;
  logic             inRoom;
  logic             outAvail;
  logic [7:0]       outByte;

  assign inRoom   = inCnt < DEPTH_L;
  assign outAvail = rdPos < outCnt;

  bt_win_ram #(.DEPTH(DEPTH), .WIDTH(8)) u_inRam (
    .clk    (clk),
    .wrEn   (strobe.pushIn && inRoom),
    .wrAddr (inCnt[IDX_W-1:0]),
    .wrData (hostWdata),
    .rdAddr (engRdAddr),
    .rdData (engRdData)
  );

  bt_win_ram #(.DEPTH(DEPTH), .WIDTH(8)) u_outRam (
    .clk    (clk),
    .wrEn   (engWrEn),
    .wrAddr (engWrAddr),
    .wrData (engWrData),
    .rdAddr (rdPos[IDX_W-1:0]),
    .rdData (outByte)
  );

  // Inbound length: counts every write, saturating at all ones.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCnt <= '0;
    end else if (strobe.clrIn) begin
      inCnt <= '0;
    end else if (strobe.pushIn && (inCnt != LEN_MAX)) begin
      inCnt <= inCnt + 1'b1;
    end
  end

  // Outbound drain. Both counters return to zero after the last byte.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPos  <= '0;
      outCnt <= '0;
    end else if (engCommit) begin
      rdPos  <= '0;
      outCnt <= (engCommitLen > DEPTH_L) ? DEPTH_L : engCommitLen;
    end else if (strobe.clrOutPos) begin
      rdPos <= '0;
    end else if (strobe.popOut && outAvail) begin
      if (rdPos + 1'b1 == outCnt) begin
        rdPos  <= '0;
        outCnt <= '0;
      end else begin
        rdPos <= rdPos + 1'b1;
      end
    end
  end

  assign bufRdByte = outAvail ? outByte : IDLE_BYTE;
  assign inLen     = inCnt;
  assign outLen    = outCnt;

endmodule

// File: rtl/bt_host_window.sv
module bt_host_window
  import bt_win_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostSel,
  input  logic                     hostWr,
  input  logic [1:0]               hostAddr,
  input  logic [7:0]               hostWdata,
  output logic [7:0]               hostRdata,
  output logic                     doorbell,
  output logic [$clog2(DEPTH)+1:0] inLen,
  input  logic [$clog2(DEPTH)-1:0] engRdAddr,
  output logic [7:0]               engRdData,
  input  logic                     engWrEn,
  input  logic [$clog2(DEPTH)-1:0] engWrAddr,
  input  logic [7:0]               engWrData,
  input  logic                     engCommit,
  input  logic [$clog2(DEPTH)+1:0] engCommitLen,
  input  logic                     engSmsSet,
  output logic [7:0]               maskByte
);

  localparam int LEN_W = $clog2(DEPTH) + 2;

  bufStrobe_t       strobe;
  logic [7:0]       bufRdByte;
  logic [7:0]       ctrlByte;
  logic [LEN_W-1:0] outLen;

  bt_win_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .bufRdByte (bufRdByte),
    .engCommit (engCommit),
    .engSmsSet (engSmsSet),
    .strobe    (strobe),
    .hostRdata (hostRdata),
    .ctrlByte  (ctrlByte),
    .maskByte  (maskByte),
    .doorbell  (doorbell)
  );

  bt_win_data #(.DEPTH(DEPTH)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .hostWdata    (hostWdata),
    .engRdAddr    (engRdAddr),
    .engRdData    (engRdData),
    .engWrEn      (engWrEn),
    .engWrAddr    (engWrAddr),
    .engWrData    (engWrData),
    .engCommit    (engCommit),
    .engCommitLen (engCommitLen),
    .bufRdByte    (bufRdByte),
    .inLen        (inLen),
    .outLen       (outLen)
  );

endmodule

// File: rtl/bt_host_window_chk.sv
module bt_host_window_chk #(
  parameter int DEPTH = 256
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     hostSel,
  input logic                     hostWr,
  input logic [1:0]               hostAddr,
  input logic [7:0]               hostWdata,
  input logic [7:0]               hostRdata,
  input logic                     doorbell,
  input logic [7:0]               ctrlByte,
  input logic [$clog2(DEPTH)+1:0] inLen,
  input logic [$clog2(DEPTH)+1:0] outLen,
  input logic                     engCommit
);

  localparam int LEN_W = $clog2(DEPTH) + 2;

  logic ctrlWrite;
  assign ctrlWrite = hostSel && hostWr && (hostAddr == 2'd0);

  // R3
  bell_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && hostWdata[2]) |=> doorbell);

  // R3
  bell_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |=> !doorbell);

  // R3
  bell_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && hostWdata[2] && !engCommit) |=> ctrlByte[7]);

  // R4
  host_busy_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && hostWdata[6]) |=> (ctrlByte[6] != $past(ctrlByte[6])));

  // R6
  in_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && hostAddr == 2'd1 && inLen != {LEN_W{1'b1}})
      |=> (inLen == $past(inLen) + 1'b1));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr && hostAddr == 2'd1 && outLen == '0)
      |-> (hostRdata == 8'hFF));

  // R10
  commit_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    engCommit |=> (ctrlByte[3] && !ctrlByte[7]));

endmodule

bind bt_host_window bt_host_window_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostSel   (hostSel),
  .hostWr    (hostWr),
  .hostAddr  (hostAddr),
  .hostWdata (hostWdata),
  .hostRdata (hostRdata),
  .doorbell  (doorbell),
  .ctrlByte  (ctrlByte),
  .inLen     (inLen),
  .outLen    (outLen),
  .engCommit (engCommit)
);

// File: tb/test_bt_host_window.sv
module test_bt_host_window;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = IDX_W + 2;

  // Vector: {isRead, addr[1:0], byte[7:0], req[3:0]}. A write uses byte as
  // data. A read compares the byte field against hostRdata.
  localparam int NVEC = 15;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'h00, 4'd1},   // R1 control
    {1'b1, 2'd2, 8'h00, 4'd1},   // R1 mask
    {1'b1, 2'd1, 8'hFF, 4'd1},   // R1 buffer empty
    {1'b1, 2'd3, 8'hFF, 4'd2},   // R2 offset 3
    {1'b0, 2'd0, 8'h40, 4'd4},
    {1'b1, 2'd0, 8'h40, 4'd4},   // R4 toggled on
    {1'b0, 2'd0, 8'h40, 4'd4},
    {1'b1, 2'd0, 8'h00, 4'd4},   // R4 toggled off
    {1'b0, 2'd2, 8'hA5, 4'd12},
    {1'b1, 2'd2, 8'hA5, 4'd12},  // R12 readback
    {1'b0, 2'd3, 8'h55, 4'd2},
    {1'b1, 2'd2, 8'hA5, 4'd2},   // R2 mask untouched
    {1'b1, 2'd0, 8'h00, 4'd2},   // R2 control untouched
    {1'b0, 2'd0, 8'h04, 4'd3},
    {1'b1, 2'd0, 8'h80, 4'd3}    // R3 busy set, bit 2 reads 0
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hostSel = 1'b0;
  logic             hostWr = 1'b0;
  logic [1:0]       hostAddr = '0;
  logic [7:0]       hostWdata = '0;
  logic [7:0]       hostRdata;
  logic             doorbell;
  logic [LEN_W-1:0] inLen;
  logic [IDX_W-1:0] engRdAddr = '0;
  logic [7:0]       engRdData;
  logic             engWrEn = 1'b0;
  logic [IDX_W-1:0] engWrAddr = '0;
  logic [7:0]       engWrData = '0;
  logic             engCommit = 1'b0;
  logic [LEN_W-1:0] engCommitLen = '0;
  logic             engSmsSet = 1'b0;
  logic [7:0]       maskByte;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bt_host_window #(.DEPTH(DEPTH)) i_bt_host_window (
    .clk          (clk),
    .rstN         (rstN),
    .hostSel      (hostSel),
    .hostWr       (hostWr),
    .hostAddr     (hostAddr),
    .hostWdata    (hostWdata),
    .hostRdata    (hostRdata),
    .doorbell     (doorbell),
    .inLen        (inLen),
    .engRdAddr    (engRdAddr),
    .engRdData    (engRdData),
    .engWrEn      (engWrEn),
    .engWrAddr    (engWrAddr),
    .engWrData    (engWrData),
    .engCommit    (engCommit),
    .engCommitLen (engCommitLen),
    .engSmsSet    (engSmsSet),
    .maskByte     (maskByte)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    hostSel = 1'b0;
  endtask

  task automatic engLoad(input logic [IDX_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    engWrEn = 1'b1; engWrAddr = a; engWrData = d;
    @(negedge clk);
    engWrEn = 1'b0;
  endtask

  task automatic engPublish(input int len);
    @(negedge clk);
    engCommit = 1'b1; engCommitLen = LEN_W'(len);
    @(negedge clk);
    engCommit = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset outputs
    check("R1 doorbell", int'(doorbell), 0);
    check("R1 inLen", int'(inLen), 0);
    check("R1 maskByte", int'(maskByte), 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][14]) begin
        hostRead(VEC[i][13:12], rd);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), int'(rd), int'(VEC[i][11:4]));
      end else begin
        hostWrite(VEC[i][13:12], VEC[i][11:4]);
      end
    end
    check("R12 maskByte port", int'(maskByte), 8'hA5);

    // R3 doorbell pulse timing
    hostWrite(2'd0, 8'h04);
    check("R3 doorbell high", int'(doorbell), 1);
    @(negedge clk);
    check("R3 doorbell single", int'(doorbell), 0);

    // R6 inbound message
    for (int i = 0; i < 5; i++) hostWrite(2'd1, 8'h10 + 8'(i));
    check("R6 inLen", int'(inLen), 5);
    engRdAddr = IDX_W'(3);
    #1 check("R6 byte3", int'(engRdData), 8'h13);

    // R10 commit
    engLoad(IDX_W'(0), 8'hC1);
    engLoad(IDX_W'(1), 8'hC2);
    engLoad(IDX_W'(2), 8'hC3);
    engPublish(3);
    hostRead(2'd0, rd);
    check("R10 control", int'(rd), 8'h08);

    // R8 drain
    hostRead(2'd1, rd); check("R8 byte0", int'(rd), 8'hC1);
    hostRead(2'd1, rd); check("R8 byte1", int'(rd), 8'hC2);
    hostRead(2'd1, rd); check("R8 byte2", int'(rd), 8'hC3);
    hostRead(2'd1, rd); check("R8 past end", int'(rd), 8'hFF);
    hostRead(2'd1, rd); check("R8 still empty", int'(rd), 8'hFF);

    // R9 reread after read-pointer clear
    engPublish(3);
    hostRead(2'd1, rd); check("R9 first", int'(rd), 8'hC1);
    hostRead(2'd1, rd); check("R9 second", int'(rd), 8'hC2);
    hostWrite(2'd0, 8'h02);
    hostRead(2'd1, rd); check("R9 reread", int'(rd), 8'hC1);

    // R5 attention clears
    engSmsSet = 1'b1;
    @(negedge clk);
    engSmsSet = 1'b0;
    hostRead(2'd0, rd); check("R11 sms set", int'(rd), 8'h18);
    hostWrite(2'd0, 8'h00);
    hostRead(2'd0, rd); check("R5 zero write keeps", int'(rd), 8'h18);
    hostWrite(2'd0, 8'h08);
    hostRead(2'd0, rd); check("R5 rsp cleared", int'(rd), 8'h10);
    hostWrite(2'd0, 8'h10);
    hostRead(2'd0, rd); check("R5 sms cleared", int'(rd), 8'h00);

    // R10 commit length limited to DEPTH
    engPublish(DEPTH + 7);
    for (int i = 0; i < DEPTH - 1; i++) hostRead(2'd1, rd);
    hostRead(2'd1, rd);
    hostRead(2'd1, rd); check("R10 length limited", int'(rd), 8'hFF);

    // R9 clear write pointer, then R7 overrun
    hostWrite(2'd0, 8'h01);
    check("R9 inLen cleared", int'(inLen), 0);
    for (int i = 0; i < DEPTH + 2; i++) hostWrite(2'd1, 8'(i) ^ 8'h3C);
    check("R7 overrun count", int'(inLen), DEPTH + 2);
    engRdAddr = '0;
    #1 check("R7 first byte intact", int'(engRdData), 8'h3C);
    engRdAddr = IDX_W'(DEPTH - 1);
    #1 check("R7 last stored byte", int'(engRdData), (DEPTH - 1) ^ 8'h3C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule